// File: doc/BRIEF.md
# Associative Processing Element with Activity Mask Stack

This block is a single parallel processing element for an associative SIMD array. Each element keeps one record, a few 16-bit fields, in its own storage, next to a small register bank. A control unit drives the same key, field index, comparison code and operation into every element at once. Each element compares its own selected field against the shared key and keeps a stack of activity bits. The top bit of that stack is the element's responder flag.

A search pushes its comparison result onto the stack, masked by the current top. A later search therefore narrows the set that the earlier searches selected. For example, one search picks a category, and a second search applies a numeric bound inside that category. Popping the stack brings the enclosing selection back in one cycle. While the top bit is 0, the element ignores data writes. Stack-combining operations and pops still run, so the element can leave a nested scope.

Top module: `apu_cell`

## Requirements
- R1: After reset, `hit` is 1 and every record field and every register reads as zero.
- R2: Opcode 3'b001 (search) compares record field `sel` with `key` as unsigned numbers. `cmp_code` selects the test: 2'b00 equal, 2'b01 not equal, 2'b10 field < key, 2'b11 field > key. The search pushes (result AND current top), and `hit` shows the pushed bit from the next cycle.
- R3: A search run while `hit` is 0 always pushes 0, so a disabled element cannot become a responder through nested searches.
- R4: Opcode 3'b011 (pop) removes the top entry in one cycle and restores the entry below it. It runs whether `hit` is 0 or 1.
- R5: A pop on an empty stack leaves `hit` at 1, and any number of further pops keep it there.
- R6: The stack holds 8 entries. A push onto a full stack discards the oldest entry, so 8 pops after an overflow empty the stack and `hit` returns to 1.
- R7: Opcode 3'b010 (duplicate) pushes a copy of the current top.
- R8: Opcode 3'b100 replaces the top with (top AND result), without pushing. It runs whether `hit` is 0 or 1.
- R9: Opcode 3'b101 replaces the top with (top OR (result AND enclosing bit)). The enclosing bit is the entry below the top, or 1 when there is no such entry. The top can therefore never rise above the enclosing selection.
- R10: Opcode 3'b110 writes `wdata` into record field `sel`, and opcode 3'b111 writes it into register `sel`. Each write takes effect only when `hit` is 1 and is otherwise ignored.
- R11: `rd_data` shows record field `sel` when `rd_bank` is 0 and register `sel` when `rd_bank` is 1, combinationally from the stored state.
- R12: Opcode 3'b000 changes neither the stack nor the storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 3 | Operation code broadcast to all elements |
| cmp_code | input | 2 | Comparison test selector |
| sel | input | 2 | Field or register index |
| key | input | 16 | Broadcast comparison key |
| wdata | input | 16 | Write data for record or register writes |
| rd_bank | input | 1 | Read source: 0 record, 1 registers |
| hit | output | 1 | Responder flag, the top of the mask stack |
| rd_data | output | 16 | Data read from the selected storage |

## Verification
A wrong stack entry shows up nowhere at first. It reaches `hit` only once pops bring it to the top, so errors in depth, overflow or refill show only after a chain of pops. The bench therefore unwinds every nested scope completely and also drives past overflow and underflow. A gating error shows up as a `rd_data` change one cycle after a write made while disabled. A comparator error shows up as a wrong `hit` one cycle after a search. The sweeps place keys one below, equal to and one above each field, at both ends of the 16-bit range.

// File: rtl/apu_pkg.sv
package apu_pkg;

   typedef enum logic [2:0] {
      OP_NOP    = 3'b000,
      OP_SEARCH = 3'b001,
      OP_DUP    = 3'b010,
      OP_POP    = 3'b011,
      OP_AND    = 3'b100,
      OP_OR     = 3'b101,
      OP_WREC   = 3'b110,
      OP_WREG   = 3'b111
   } apu_op_e;

   typedef enum logic [1:0] {
      CMP_EQ = 2'b00,
      CMP_NE = 2'b01,
      CMP_LT = 2'b10,
      CMP_GT = 2'b11
   } apu_cmp_e;

endpackage

// File: rtl/apu_cmp.sv
module apu_cmp
   import apu_pkg::*;
#(
   parameter int W      = 16,
   parameter bit SUB_LT = 1'b1
) (
   input  logic [W-1:0] field_i,
   input  logic [W-1:0] key_i,
   input  apu_cmp_e     code_i,
   output logic         res_o
);

   logic lt;
   logic eq;
   logic gt;

   generate
      if (SUB_LT) begin : g_sub
         logic [W:0] diff;
         assign diff = {1'b0, field_i} - {1'b0, key_i};
         assign lt   = diff[W];
      end else begin : g_rel
         assign lt = (field_i < key_i);
      end
   endgenerate

   assign eq = (field_i == key_i);
   assign gt = ~lt & ~eq;

   always_comb begin
      unique case (code_i)
         CMP_EQ:  res_o = eq;
         CMP_NE:  res_o = ~eq;
         CMP_LT:  res_o = lt;
         CMP_GT:  res_o = gt;
         default: res_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/apu_mask_stack.sv
module apu_mask_stack #(
   parameter int DEPTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push_i,
   input  logic pop_i,
   input  logic set_i,
   input  logic push_val_i,
   input  logic set_val_i,
   output logic top_o,
   output logic below_o
);

   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("apu_mask_stack: DEPTH must be at least 2");
      end
   endgenerate

   logic [DEPTH-1:0] stk;
   logic [CW-1:0]    cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stk <= '1;
         cnt <= '0;
      end else if (push_i) begin
         stk <= {stk[DEPTH-2:0], push_val_i};
         if (cnt != CW'(DEPTH))
            cnt <= cnt + 1'b1;
      end else if (pop_i) begin
         stk <= {1'b1, stk[DEPTH-1:1]};
         if (cnt != '0)
            cnt <= cnt - 1'b1;
      end else if (set_i) begin
         stk[0] <= set_val_i;
      end
   end

   assign top_o   = stk[0];
   assign below_o = stk[1];

   p_depth_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   p_fill_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt < CW'(DEPTH)) |-> stk[cnt[IW-1:0]]);

   p_pop_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i) |=> (top_o == $past(below_o)));

   p_push_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> (top_o == $past(push_val_i)));

endmodule

// File: rtl/apu_bank.sv
module apu_bank #(
   parameter int W = 16,
   parameter int N = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we_i,
   input  logic [$clog2(N)-1:0] waddr_i,
   input  logic [W-1:0]         wdata_i,
   input  logic [$clog2(N)-1:0] raddr_i,
   output logic [W-1:0]         rdata_o,
   output logic [N*W-1:0]       words_o
);

   localparam int AW = $clog2(N);

   logic [W-1:0] word [N];

   generate
      for (genvar i = 0; i < N; i++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word[i] <= '0;
            else if (we_i && (waddr_i == AW'(i)))
               word[i] <= wdata_i;
         end
         assign words_o[i*W +: W] = word[i];
      end
   endgenerate

   assign rdata_o = word[raddr_i];

endmodule

// File: rtl/apu_cell.sv
module apu_cell
   import apu_pkg::*;
#(
   parameter int FIELD_W     = 16,
   parameter int ENTRIES     = 4,
   parameter int STACK_DEPTH = 8,
   parameter bit CMP_SUBTRACT = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [2:0]                 op,
   input  logic [1:0]                 cmp_code,
   input  logic [$clog2(ENTRIES)-1:0] sel,
   input  logic [FIELD_W-1:0]         key,
   input  logic [FIELD_W-1:0]         wdata,
   input  logic                       rd_bank,
   output logic                       hit,
   output logic [FIELD_W-1:0]         rd_data
);

   localparam int FLAT_W = ENTRIES * FIELD_W;

   generate
      if (FIELD_W < 1) begin : g_bad_width
         $error("apu_cell: FIELD_W must be positive");
      end
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
         $error("apu_cell: ENTRIES must be a power of two, at least 2");
      end
      if (STACK_DEPTH < 2) begin : g_bad_stack
         $error("apu_cell: STACK_DEPTH must be at least 2");
      end
   endgenerate

   apu_op_e            op_e;
   logic               top;
   logic               below;
   logic               cmp_res;
   logic [FIELD_W-1:0] rec_q;
   logic [FIELD_W-1:0] reg_q;
   logic [FLAT_W-1:0]  rec_all;
   logic [FLAT_W-1:0]  reg_all;
   logic               do_push;
   logic               do_pop;
   logic               do_set;
   logic               push_val;
   logic               set_val;
   logic               rec_we;
   logic               reg_we;

   assign op_e = apu_op_e'(op);

   apu_cmp #(
      .W      (FIELD_W),
      .SUB_LT (CMP_SUBTRACT)
   ) u_cmp (
      .field_i (rec_q),
      .key_i   (key),
      .code_i  (apu_cmp_e'(cmp_code)),
      .res_o   (cmp_res)
   );

   always_comb begin
      do_push  = 1'b0;
      do_pop   = 1'b0;
      do_set   = 1'b0;
      push_val = top;
      set_val  = top;
      rec_we   = 1'b0;
      reg_we   = 1'b0;
      unique case (op_e)
         OP_SEARCH: begin
            do_push  = 1'b1;
            push_val = cmp_res & top;
         end
         OP_DUP: begin
            do_push  = 1'b1;
            push_val = top;
         end
         OP_POP: do_pop = 1'b1;
         OP_AND: begin
            do_set  = 1'b1;
            set_val = top & cmp_res;
         end
         OP_OR: begin
            do_set  = 1'b1;
            set_val = top | (cmp_res & below);
         end
         OP_WREC: rec_we = top;
         OP_WREG: reg_we = top;
         default: ;
      endcase
   end

   apu_mask_stack #(
      .DEPTH (STACK_DEPTH)
   ) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (do_push),
      .pop_i      (do_pop),
      .set_i      (do_set),
      .push_val_i (push_val),
      .set_val_i  (set_val),
      .top_o      (top),
      .below_o    (below)
   );

   apu_bank #(
      .W (FIELD_W),
      .N (ENTRIES)
   ) u_rec (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (rec_we),
      .waddr_i (sel),
      .wdata_i (wdata),
      .raddr_i (sel),
      .rdata_o (rec_q),
      .words_o (rec_all)
   );

   apu_bank #(
      .W (FIELD_W),
      .N (ENTRIES)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (reg_we),
      .waddr_i (sel),
      .wdata_i (wdata),
      .raddr_i (sel),
      .rdata_o (reg_q),
      .words_o (reg_all)
   );

   assign hit     = top;
   assign rd_data = rd_bank ? reg_q : rec_q;

   p_search_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e == OP_SEARCH && !hit) |=> !hit);

   p_and_narrows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e == OP_AND && !hit) |=> !hit);

   p_or_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e == OP_OR && !below) |=> (hit == $past(hit)));

   p_rec_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e != OP_WREC || !hit) |=> $stable(rec_all));

   p_reg_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e != OP_WREG || !hit) |=> $stable(reg_all));

   p_nop_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e == OP_NOP) |=> $stable(hit));

endmodule

// File: tb/apu_cell_test.sv
module apu_cell_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op = 3'b000;
   logic [1:0]  cmp_code = 2'b00;
   logic [1:0]  sel = 2'b00;
   logic [15:0] key = '0;
   logic [15:0] wdata = '0;
   logic        rd_bank = 1'b0;
   logic        hit;
   logic [15:0] rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   bit          mstk [8];
   logic [15:0] mrec [4];
   logic [15:0] mreg [4];

   apu_cell uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .cmp_code (cmp_code),
      .sel      (sel),
      .key      (key),
      .wdata    (wdata),
      .rd_bank  (rd_bank),
      .hit      (hit),
      .rd_data  (rd_data)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit fcmp(input logic [15:0] f, input logic [15:0] k, input logic [1:0] c);
      case (c)
         2'd0:    return f == k;
         2'd1:    return f != k;
         2'd2:    return f < k;
         default: return f > k;
      endcase
   endfunction

   task automatic mpush(input bit b);
      for (int i = 7; i > 0; i--) mstk[i] = mstk[i-1];
      mstk[0] = b;
   endtask

   task automatic mpop();
      for (int i = 0; i < 7; i++) mstk[i] = mstk[i+1];
      mstk[7] = 1'b1;
   endtask

   task automatic run(input logic [2:0] o, input logic [1:0] c, input logic [1:0] s,
                      input logic [15:0] k, input logic [15:0] wd, input bit bank,
                      input string tag);
      bit res;
      bit t;
      bit b;
      @(negedge clk);
      op = o; cmp_code = c; sel = s; key = k; wdata = wd; rd_bank = bank;
      res = fcmp(mrec[s], k, c);
      t = mstk[0];
      b = mstk[1];
      case (o)
         3'd1: mpush(res & t);
         3'd2: mpush(t);
         3'd3: mpop();
         3'd4: mstk[0] = t & res;
         3'd5: mstk[0] = t | (res & b);
         3'd6: if (t) mrec[s] = wd;
         3'd7: if (t) mreg[s] = wd;
         default: ;
      endcase
      @(negedge clk);
      chk({tag, " hit"}, {15'd0, hit}, {15'd0, mstk[0]});
      chk({tag, " rd_data"}, rd_data, bank ? mreg[s] : mrec[s]);
      op = 3'd0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] vals [4];
      logic [15:0] keys [5];
      vals[0] = 16'h0000; vals[1] = 16'h7FFF; vals[2] = 16'h8000; vals[3] = 16'hFFFF;
      for (int i = 0; i < 8; i++) mstk[i] = 1'b1;
      for (int i = 0; i < 4; i++) begin mrec[i] = '0; mreg[i] = '0; end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 hit", {15'd0, hit}, 16'd1);
      for (int i = 0; i < 8; i++) begin
         sel = 2'(i % 4); rd_bank = (i >= 4);
         #1;
         chk("R1 storage", rd_data, 16'h0000);
      end

      // R10, R11: enabled writes to both banks, read back
      for (int i = 0; i < 4; i++) run(3'd6, 2'd0, 2'(i), 16'd0, vals[i], 1'b0, "R10 rec write");
      for (int i = 0; i < 4; i++) run(3'd7, 2'd0, 2'(i), 16'd0, 16'hA500 + 16'(i), 1'b1, "R10 reg write");
      for (int i = 0; i < 4; i++) run(3'd0, 2'd0, 2'(i), 16'd0, 16'd0, 1'b1, "R11 reg read");

      // R2, R4: comparator sweep, each search popped back off
      for (int f = 0; f < 4; f++) begin
         keys[0] = vals[f] - 16'd1; keys[1] = vals[f]; keys[2] = vals[f] + 16'd1;
         keys[3] = 16'h0000; keys[4] = 16'hFFFF;
         for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 5; k++) begin
               run(3'd1, 2'(c), 2'(f), keys[k], 16'd0, 1'b0, "R2 search");
               run(3'd3, 2'd0, 2'(f), 16'd0, 16'd0, 1'b0, "R4 pop");
            end
         end
      end

      // R3: nested narrowing, disabled element stays out
      run(3'd1, 2'd0, 2'd3, 16'hFFFF, 16'd0, 1'b0, "R3 outer true");
      run(3'd1, 2'd2, 2'd1, 16'h0100, 16'd0, 1'b0, "R3 inner false");
      run(3'd1, 2'd0, 2'd0, 16'h0000, 16'd0, 1'b0, "R3 gated true");
      // R10: writes ignored while disabled
      run(3'd6, 2'd0, 2'd2, 16'd0, 16'h1234, 1'b0, "R10 rec blocked");
      run(3'd7, 2'd0, 2'd2, 16'd0, 16'h5678, 1'b1, "R10 reg blocked");
      // R12: no-ops hold state
      run(3'd0, 2'd0, 2'd2, 16'd0, 16'h0000, 1'b0, "R12 nop");
      run(3'd0, 2'd1, 2'd1, 16'd5, 16'hFFFF, 1'b0, "R12 nop");
      // R4: pops while disabled
      run(3'd3, 2'd0, 2'd0, 16'd0, 16'd0, 1'b0, "R4 pop disabled");
      run(3'd3, 2'd0, 2'd0, 16'd0, 16'd0, 1'b0, "R4 pop disabled");
      run(3'd3, 2'd0, 2'd0, 16'd0, 16'd0, 1'b0, "R4 pop outer");

      // R8, R9: combine into top
      run(3'd1, 2'd0, 2'd0, 16'h0000, 16'd0, 1'b0, "R8 setup");
      run(3'd4, 2'd1, 2'd0, 16'h0000, 16'd0, 1'b0, "R8 and false");
      run(3'd4, 2'd0, 2'd0, 16'h0000, 16'd0, 1'b0, "R8 and on zero");
      run(3'd5, 2'd0, 2'd1, 16'h7FFF, 16'd0, 1'b0, "R9 or revive");
      run(3'd1, 2'd1, 2'd1, 16'h7FFF, 16'd0, 1'b0, "R9 push zero");
      run(3'd1, 2'd0, 2'd1, 16'h7FFF, 16'd0, 1'b0, "R9 nested zero");
      run(3'd5, 2'd0, 2'd1, 16'h7FFF, 16'd0, 1'b0, "R9 or bounded");
      run(3'd3, 2'd0, 2'd0, 16'd0, 16'd0, 1'b0, "R9 pop");
      run(3'd5, 2'd0, 2'd1, 16'h7FFF, 16'd0, 1'b0, "R9 or below one");
      for (int i = 0; i < 3; i++) run(3'd3, 2'd0, 2'd0, 16'd0, 16'd0, 1'b0, "R4 unwind");

      // R7: duplicate
      run(3'd1, 2'd1, 2'd0, 16'h0000, 16'd0, 1'b0, "R7 setup zero");
      run(3'd2, 2'd0, 2'd0, 16'd0, 16'd0, 1'b0, "R7 dup");
      run(3'd3, 2'd0, 2'd0, 16'd0, 16'd0, 1'b0, "R7 pop dup");
      run(3'd3, 2'd0, 2'd0, 16'd0, 16'd0, 1'b0, "R7 pop base");

      // R6: overflow drops oldest, R5: underflow keeps one
      run(3'd1, 2'd0, 2'd0, 16'h0000, 16'd0, 1'b0, "R6 push true");
      run(3'd1, 2'd1, 2'd0, 16'h0000, 16'd0, 1'b0, "R6 push false");
      for (int i = 0; i < 7; i++) run(3'd2, 2'd0, 2'd0, 16'd0, 16'd0, 1'b0, "R6 fill");
      for (int i = 0; i < 8; i++) run(3'd3, 2'd0, 2'd0, 16'd0, 16'd0, 1'b0, "R6 drain");
      for (int i = 0; i < 4; i++) run(3'd3, 2'd0, 2'd0, 16'd0, 16'd0, 1'b0, "R5 underflow");
      run(3'd1, 2'd3, 2'd2, 16'h7FFF, 16'd0, 1'b0, "R5 search after underflow");
      run(3'd3, 2'd0, 2'd2, 16'd0, 16'd0, 1'b0, "R5 pop back");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule